// File: doc/BRIEF.md
# Serial Receive Carrier-Gated Byte Deserializer

This block takes a bit-serial receive stream, one bit per clock, and packs it into bytes. Whether a bit counts is decided by an active-low carrier line. In the level-gated mode that line frames the data directly. In the software mode the line is treated inside the block as always asserted, but its true level and a change pulse are still reported. In the sync mode a single falling edge on the line locks the receiver, and it then ignores the line completely.

The carrier line, the data bit and the hunt command pass through one shared two-stage synchronizer bank. That keeps all three aligned to the same bit position. A hunt command drops any partial byte and sends the receiver back to searching for its start condition. In the sync mode, a hunt is the only way to leave the locked state. The mode input is configuration and is expected to stay stable while data is flowing.

Top module: `rx_cd_sync`

## Requirements
- R1: `cd_ni`, `rx_bit_i` and `hunt_i` each pass through two register stages before they are used. `cd_level_o` shows the `cd_ni` level two clocks late and reads 1 out of reset.
- R2: Accepted bits are packed LSB first. `byte_vld_o` is high for exactly one clock for every 8 accepted bits, together with the byte on `byte_o`. If the first bit is driven before clock edge k, `byte_vld_o` is high after edge k+9.
- R3: Level-gated mode (`mode_i` = 2'b00, and also 2'b11) accepts bits only while the synchronized carrier is low. A frame starts at the first low sample. If the carrier rises when no partial byte is held, `eof_o` pulses for one clock and no error is raised.
- R4: If the carrier rises in level-gated mode while 1 to 7 bits are held, `eof_o` pulses and the partial bits are dropped. `cd_lost_o` is then set and stays set until the next frame starts.
- R5: Software mode (`mode_i` = 2'b01) treats the carrier as always low and never ends a frame. `cd_chg_o` gives one pulse per change of the synchronized carrier level, and it never pulses in the other modes.
- R6: Sync mode (`mode_i` = 2'b10) starts at a high-to-low change of the synchronized carrier, and the bit seen with that low sample is the first bit of the frame. After that, every bit is accepted whatever the carrier does.
- R7: The bit that arrives with a hunt command is discarded, along with any partial byte, and the receiver returns to hunting. In sync mode, a carrier that is already low does not restart reception. A fresh high-to-low change is required.
- R8: During reset `byte_vld_o`, `eof_o`, `cd_lost_o` and `cd_chg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 level-gated, 01 software, 10 sync, 11 level-gated |
| hunt_i | input | 1 | Re-arm command, aligned with the data bit |
| rx_bit_i | input | 1 | Serial data bit |
| cd_ni | input | 1 | Carrier detect / sync line, active low |
| byte_o | output | 8 | Last assembled byte |
| byte_vld_o | output | 1 | One-clock strobe for `byte_o` |
| eof_o | output | 1 | One-clock frame-end pulse |
| cd_lost_o | output | 1 | Carrier lost in the middle of a byte |
| cd_level_o | output | 1 | Synchronized carrier level |
| cd_chg_o | output | 1 | Carrier change pulse in software mode |

## Verification
The hardest case to reach is the locked sync state when the carrier is already low. Proving that reception does not restart needs three things in order: a hunt issued while the line is still low, data that must produce no bytes, and then a release-and-fall of the line that must restart reception. The bench also toggles the carrier in the middle of a byte while locked. It then checks that the byte stream is unchanged, so that ignored transitions are seen only at the ports. A full sweep of all 256 byte values in one level-gated frame covers the bit ordering.

// File: rtl/rx_cd_pkg.sv
package rx_cd_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_SW    = 2'b01,
    MODE_EXT   = 2'b10,
    MODE_RSV   = 2'b11
  } rx_mode_e;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RUN  = 1'b1
  } rx_state_e;
endpackage

// File: rtl/rx_cd_sync_bank.sv
module rx_cd_sync_bank #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rx_cd_gate.sv
module rx_cd_gate
  import rx_cd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rx_mode_e mode_i,
  input  logic     cd_s_i,
  input  logic     hunt_i,
  input  logic     mid_byte_i,
  output logic     gate_o,
  output logic     clr_o,
  output logic     eof_o,
  output logic     lost_o,
  output logic     cd_chg_o
);
  rx_state_e state_q, state_d;
  logic cd_prev_q;
  logic eff_low, start_cond, start, end_frame;
  logic eof_q, lost_q;

  // software mode forces carrier low internally
  assign eff_low    = (mode_i == MODE_SW) | ~cd_s_i;
  assign start_cond = (mode_i == MODE_EXT) ? (cd_prev_q & ~cd_s_i) : eff_low;

  always_comb begin
    state_d   = state_q;
    gate_o    = 1'b0;
    start     = 1'b0;
    end_frame = 1'b0;
    if (hunt_i) begin
      state_d = ST_HUNT;
    end else begin
      unique case (state_q)
        ST_HUNT: begin
          if (start_cond) begin
            gate_o  = 1'b1;
            start   = 1'b1;
            state_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (mode_i == MODE_EXT || eff_low) begin
            gate_o = 1'b1;
          end else begin
            end_frame = 1'b1;
            state_d   = ST_HUNT;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  assign clr_o = hunt_i | end_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      cd_prev_q <= 1'b1;
      eof_q     <= 1'b0;
      lost_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cd_prev_q <= cd_s_i;
      eof_q     <= end_frame;
      if (start)                        lost_q <= 1'b0;
      else if (end_frame && mid_byte_i) lost_q <= 1'b1;
    end
  end

  assign eof_o    = eof_q;
  assign lost_o   = lost_q;
  assign cd_chg_o = (mode_i == MODE_SW) & (cd_s_i ^ cd_prev_q);

  AST_LOST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_q && !start) |=> lost_q); // R4
  AST_EXT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EXT && state_q == ST_RUN && !hunt_i) |=> (state_q == ST_RUN)); // R6
  AST_SW_NO_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SW) |=> !eof_q); // R5
endmodule

// File: rtl/rx_cd_shifter.sv
module rx_cd_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gate_i,
  input  logic         clr_i,
  input  logic         bit_i,
  output logic [W-1:0] byte_o,
  output logic         vld_o,
  output logic         mid_byte_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q, byte_q;
  logic [CW-1:0] cnt_q;
  logic          vld_q;
  logic [W-1:0]  sh_nxt;

  assign sh_nxt = {bit_i, sh_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      byte_q <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (gate_i) begin
        sh_q <= sh_nxt;
        if (cnt_q == LAST) begin
          byte_q <= sh_nxt;
          vld_q  <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_o     = byte_q;
  assign vld_o      = vld_q;
  assign mid_byte_o = (cnt_q != '0);

  AST_VLD_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q); // R2
  AST_CLR_NO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !vld_q); // R7
endmodule

// File: rtl/rx_cd_sync.sv
module rx_cd_sync
  import rx_cd_pkg::*;
#(
  parameter int W        = 8,
  parameter int SYNC_STG = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         hunt_i,
  input  logic         rx_bit_i,
  input  logic         cd_ni,
  output logic [W-1:0] byte_o,
  output logic         byte_vld_o,
  output logic         eof_o,
  output logic         cd_lost_o,
  output logic         cd_level_o,
  output logic         cd_chg_o
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] SYNC_RST = 3'b100; // carrier idles high

  logic [NSIG-1:0] raw, synced;
  logic cd_s, bit_s, hunt_s;
  logic gate, clr, mid_byte;
  rx_mode_e mode;

  assign raw  = {cd_ni, hunt_i, rx_bit_i};
  assign mode = rx_mode_e'(mode_i);

  rx_cd_sync_bank #(.WIDTH(NSIG), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign cd_s   = synced[2];
  assign hunt_s = synced[1];
  assign bit_s  = synced[0];

  rx_cd_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .cd_s_i    (cd_s),
    .hunt_i    (hunt_s),
    .mid_byte_i(mid_byte),
    .gate_o    (gate),
    .clr_o     (clr),
    .eof_o     (eof_o),
    .lost_o    (cd_lost_o),
    .cd_chg_o  (cd_chg_o)
  );

  rx_cd_shifter #(.W(W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_i    (gate),
    .clr_i     (clr),
    .bit_i     (bit_s),
    .byte_o    (byte_o),
    .vld_o     (byte_vld_o),
    .mid_byte_o(mid_byte)
  );

  assign cd_level_o = cd_s;

  AST_LOST_NEEDS_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cd_lost_o) |-> eof_o); // R4
endmodule

// File: tb/rx_cd_sync_tb.sv
`timescale 1ns/1ps
module rx_cd_sync_tb;
  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic [1:0] mode_i = 2'b00;
  logic       hunt_i = 0;
  logic       rx_bit_i = 0;
  logic       cd_ni = 1;
  logic [7:0] byte_o;
  logic       byte_vld_o, eof_o, cd_lost_o, cd_level_o, cd_chg_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [7:0] got [512];
  int ngot = 0, eof_cnt = 0, chg_cnt = 0;
  int first_vld = -1;
  bit done = 0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  rx_cd_sync u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .hunt_i(hunt_i),
    .rx_bit_i(rx_bit_i), .cd_ni(cd_ni), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
    .eof_o(eof_o), .cd_lost_o(cd_lost_o), .cd_level_o(cd_level_o), .cd_chg_o(cd_chg_o)
  );

  always @(negedge clk_i) if (rst_ni) begin
    if (byte_vld_o) begin
      if (ngot < 512) got[ngot] = byte_o;
      ngot++;
      if (first_vld < 0) first_vld = cyc;
    end
    if (eof_o) eof_cnt++;
    if (cd_chg_o) chg_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drv(input logic b, input logic cd, input logic h);
    @(negedge clk_i);
    rx_bit_i = b; cd_ni = cd; hunt_i = h;
  endtask

  task automatic set_mode(input logic [1:0] m, input logic cd, input logic h);
    @(negedge clk_i);
    mode_i = m; rx_bit_i = 0; cd_ni = cd; hunt_i = h;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic cd);
    for (int i = 0; i < 8; i++) drv(v[i], cd, 0);
  endtask

  task automatic idle(input int n, input logic cd);
    for (int i = 0; i < n; i++) drv(0, cd, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base, c0, exp_chg, tog;
    logic cdv, prev;
    repeat (3) @(negedge clk_i);
    // R8 / R1 reset state
    check("R8 vld", byte_vld_o, 0);
    check("R8 eof", eof_o, 0);
    check("R8 lost", cd_lost_o, 0);
    check("R8 chg", cd_chg_o, 0);
    check("R1 level", cd_level_o, 1);
    rst_ni = 1;
    idle(4, 1);

    // R3: bits with carrier high ignored
    send_byte(8'hA5, 1);
    idle(4, 1);
    check("R3 ignored", ngot, 0);

    // R2 sweep: all byte values in one level-gated frame
    first_vld = -1;
    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < 8; i++) begin
        drv(v[i], 0, 0);
        if (v == 0 && i == 0) c0 = cyc;
      end
    end
    idle(6, 1);
    check("R2 latency", first_vld, c0 + 10);
    check("R2 count", ngot, 256);
    for (int v = 0; v < 256; v++) check("R2 byte", got[v], v);
    check("R3 clean eof", eof_cnt, 1);
    check("R3 no lost", cd_lost_o, 0);
    check("R5 no chg in level mode", chg_cnt, 0);

    // R4: loss mid-byte
    send_byte(8'h3C, 0);
    drv(1, 0, 0); drv(0, 0, 0); drv(1, 0, 0);
    idle(6, 1);
    check("R4 count", ngot, 257);
    check("R4 byte", got[256], 8'h3C);
    check("R4 eof", eof_cnt, 2);
    check("R4 lost set", cd_lost_o, 1);
    idle(20, 1);
    check("R4 lost held", cd_lost_o, 1);
    for (int i = 0; i < 8; i++) begin
      drv(i[0] ? 1'b0 : 1'b1, 0, 0);
      if (i == 3) begin
        @(posedge clk_i); #1;
        check("R4 lost cleared at start", cd_lost_o, 0);
      end
    end
    idle(6, 1);
    check("R4 new frame byte", got[257], 8'h55);
    check("R4 new frame eof", eof_cnt, 3);

    // R5: software mode
    chg_cnt = 0; base = ngot;
    set_mode(2'b01, 1, 1);
    prev = 1; tog = 0;
    for (int i = 0; i < 24; i++) begin
      logic [7:0] bv;
      bv = (i < 8) ? 8'hF0 : (i < 16) ? 8'h0F : 8'hC3;
      cdv = (i >= 16) ? 1'b0 : (((i / 5) % 2) == 0 ? 1'b0 : 1'b1);
      if (cdv != prev) tog++;
      prev = cdv;
      drv(bv[i % 8], cdv, 0);
    end
    exp_chg = tog;
    set_mode(2'b00, 1, 0);
    idle(6, 1);
    check("R5 count", ngot - base, 3);
    check("R5 b0", got[base], 8'hF0);
    check("R5 b1", got[base+1], 8'h0F);
    check("R5 b2", got[base+2], 8'hC3);
    check("R5 chg pulses", chg_cnt, exp_chg);
    check("R5 eof only after leaving", eof_cnt, 4);
    check("R5 no lost", cd_lost_o, 0);

    // R6: sync mode, later transitions ignored
    chg_cnt = 0; base = ngot;
    set_mode(2'b10, 1, 1);
    idle(4, 1);
    send_byte(8'h5A, 0);
    for (int i = 0; i < 8; i++) drv(i[0] ^ i[1], (i >= 2 && i <= 5) ? 1'b1 : 1'b0, 0);
    send_byte(8'h19, 0);
    drv(0, 0, 1);
    idle(4, 0);
    check("R6 count", ngot - base, 3);
    check("R6 b0", got[base], 8'h5A);
    check("R6 b1 toggles ignored", got[base+1], 8'h66);
    check("R6 b2", got[base+2], 8'h19);
    check("R6 no eof", eof_cnt, 4);
    check("R6 no chg", chg_cnt, 0);
    check("R1 level low", cd_level_o, 0);

    // R7: hunt with carrier already low does not restart
    send_byte(8'h55, 0);
    idle(12, 0);
    check("R7 no restart", ngot - base, 3);
    idle(3, 1);
    send_byte(8'h66, 0);
    drv(0, 0, 1);
    idle(4, 1);
    check("R7 restart count", ngot - base, 4);
    check("R7 restart byte", got[base+3], 8'h66);

    // R7: hunt mid-byte in level mode drops partial
    base = ngot;
    set_mode(2'b00, 1, 0);
    idle(4, 1);
    send_byte(8'h12, 0);
    drv(1, 0, 0); drv(0, 0, 0); drv(1, 0, 0); drv(1, 0, 0);
    drv(1, 0, 1);
    send_byte(8'h34, 0);
    idle(6, 1);
    check("R7 level count", ngot - base, 2);
    check("R7 level b0", got[base], 8'h12);
    check("R7 level b1", got[base+1], 8'h34);
    check("R7 level eof", eof_cnt, 5);
    check("R7 level no lost", cd_lost_o, 0);

    finish_run();
  end
endmodule